// File: doc/BRIEF.md
# Host Register Access Interface

This block sits between a CPU-style parallel bus and the internal RAMs of a character display controller. The host presents a two-bit target select, a read/write line and write data, then pulses an enable strobe; the block synchronizes the strobe into its core clock and acts once on the falling edge. Three targets are reachable: a write-only command register, a data port and an extension register. The fourth select code reaches nothing.

Writing an address-set command to the command or extension register points the internal address counter at one of three memories: display, glyph pattern or arbitrator. The block then fetches the word at that address into the data port on its own, so the next data read needs no dummy access. Each data write is committed to the chosen memory at the counter's address. Each data read returns the buffered word and then fetches the next word. After every data access the counter steps by one, upward or downward, and wraps within the size of the chosen memory. A busy flag covers each internal operation. Writes that arrive while it is set are dropped.

Top module: `host_reg_if`

## Requirements
- R1: After reset the busy flag is 0, a status read returns 0x00, an extension read returns 0x00 and the data port holds 0x00.
- R2: The select input `bus_rs_i` encodes {RS1,RS0}: 2'b11 is the data port, 2'b10 the command register, 2'b00 the extension register. A read returns the selected target's value on `bus_rdata_o` while the strobe is high. The access takes effect on the synchronized falling edge of the strobe.
- R3: Select code 2'b01 reaches nothing. A read returns 0x00. A write changes no state, raises no busy flag and issues no memory request.
- R4: A read with the command select returns the busy flag on bit 7 and the address counter on bits 6..0.
- R5: Address set. A command write with bit 7 = 1 selects the display memory at bits 6..0 modulo DISP_DEPTH. A command write with bits 7..6 = 01 selects the pattern memory at bits 5..0 modulo PAT_DEPTH. An extension write with bit 7 = 1 selects the arbitrator memory at bits 6..0 modulo ARB_DEPTH. An extension write with bit 7 = 0 stores bits 4..0 as the contrast code. An extension read returns {3'b000, contrast}.
- R6: After any address set, the data port holds the selected memory's word at the new address.
- R7: A data write stores the byte in the data port and issues one memory write (`mem_sel_o` 0 display, 1 pattern, 2 arbitrator) at the counter's address. The counter then steps.
- R8: A data read returns the buffered word. The counter then steps, and the word at the new address is fetched into the data port.
- R9: The counter steps up when `cfg_inc_i` is 1 and down when it is 0. It wraps from depth-1 to 0 going up and from 0 to depth-1 going down, and it always stays below the selected memory's depth.
- R10: Every accepted write and every data read sets the busy flag. The flag stays set for at least BUSY_CYCLES core cycles and until any memory traffic completes. Writes and data reads that arrive while it is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Host enable strobe, asynchronous, acted on at falling edge |
| bus_rw_i | input | 1 | 1 = read, 0 = write |
| bus_rs_i | input | 2 | Target select {RS1,RS0} |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data for the current select |
| busy_o | output | 1 | Internal operation in progress |
| cfg_inc_i | input | 1 | Counter step direction, 1 = up |
| mem_req_o | output | 1 | Memory access request, one cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_sel_o | output | 2 | Memory select: 0 display, 1 pattern, 2 arbitrator |
| mem_addr_o | output | 7 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read request |

## Verification
A wrong counter appears on the very next status read. It also appears as the address of the next memory write, one cycle after that write's strobe is accepted. A wrong memory select or a missed prefetch appears on the next data read, as a byte that does not match the reference memory image. Busy-window errors appear one of two ways: as an unexpected memory write, which the per-cycle port monitor reports in the cycle it happens, or as a moved counter after a write that should have been dropped.

// File: rtl/host_reg_pkg.sv
package host_reg_pkg;
  typedef enum logic [1:0] {
    RS_EXT   = 2'b00,
    RS_NONE  = 2'b01,
    RS_CMD   = 2'b10,
    RS_DATA  = 2'b11
  } rsel_e;

  typedef enum logic [1:0] {
    TGT_DISP = 2'b00,
    TGT_PAT  = 2'b01,
    TGT_ARB  = 2'b10
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PF_REQ,
    ST_PF_CAP
  } hri_st_e;
endpackage

// File: rtl/hri_strobe_sync.sv
module hri_strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= en_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;

  a_r2_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/hri_busy_timer.sv
module hri_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0) | hold_i;

  a_r10_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/hri_addr_step.sv
module hri_addr_step
  import host_reg_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DISP_DEPTH = 80,
  parameter int PAT_DEPTH  = 64,
  parameter int ARB_DEPTH  = 24
) (
  input  tgt_e              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              up_i,
  output logic [ADDR_W-1:0] next_o,
  output logic [ADDR_W:0]   depth_o
);
  int depth;

  always_comb begin
    unique case (sel_i)
      TGT_PAT: depth = PAT_DEPTH;
      TGT_ARB: depth = ARB_DEPTH;
      default: depth = DISP_DEPTH;
    endcase
    depth_o = (ADDR_W+1)'(depth);
    if (up_i) next_o = (int'(addr_i) >= depth - 1) ? '0 : addr_i + 1'b1;
    else      next_o = (addr_i == '0) ? ADDR_W'(depth - 1) : addr_i - 1'b1;
  end
endmodule

// File: rtl/host_reg_if.sv
module host_reg_if
  import host_reg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DISP_DEPTH  = 80,
  parameter int PAT_DEPTH   = 64,
  parameter int ARB_DEPTH   = 24,
  parameter int CON_W       = 5,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_rw_i,
  input  logic [1:0]        bus_rs_i,
  input  logic [ADDR_W:0]   bus_wdata_i,
  output logic [ADDR_W:0]   bus_rdata_o,
  output logic              busy_o,
  input  logic              cfg_inc_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W:0]   mem_wdata_o,
  input  logic [ADDR_W:0]   mem_rdata_i
);
  localparam int DATA_W = ADDR_W + 1;

  rsel_e             rs;
  hri_st_e           st_q;
  tgt_e              sel_q;
  logic [ADDR_W-1:0] adc_q, adc_step, wr_addr_q;
  logic [ADDR_W:0]   depth;
  logic [DATA_W-1:0] dr_q;
  logic [CON_W-1:0]  con_q;
  logic              wr_q, fall, acc_wr, acc_rd, hold;

  function automatic logic [ADDR_W-1:0] wrap_set(input int raw, input int dep);
    return ADDR_W'(raw % dep);
  endfunction

  hri_strobe_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (bus_en_i),
    .fall_o(fall)
  );

  hri_addr_step #(
    .ADDR_W    (ADDR_W),
    .DISP_DEPTH(DISP_DEPTH),
    .PAT_DEPTH (PAT_DEPTH),
    .ARB_DEPTH (ARB_DEPTH)
  ) u_step (
    .sel_i  (sel_q),
    .addr_i (adc_q),
    .up_i   (cfg_inc_i),
    .next_o (adc_step),
    .depth_o(depth)
  );

  assign hold = wr_q | (st_q != ST_IDLE);

  hri_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(acc_wr | acc_rd),
    .hold_i (hold),
    .busy_o (busy_o)
  );

  assign rs     = rsel_e'(bus_rs_i);
  assign acc_wr = fall & ~bus_rw_i & (rs != RS_NONE) & ~busy_o;
  assign acc_rd = fall &  bus_rw_i & (rs == RS_DATA) & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sel_q     <= TGT_DISP;
      adc_q     <= '0;
      wr_addr_q <= '0;
      dr_q      <= '0;
      con_q     <= '0;
      wr_q      <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      unique case (st_q)
        ST_PF_REQ: st_q <= ST_PF_CAP;
        ST_PF_CAP: begin
          dr_q <= mem_rdata_i;
          st_q <= ST_IDLE;
        end
        default: ;
      endcase
      if (acc_rd) begin
        adc_q <= adc_step;
        st_q  <= ST_PF_REQ;
      end
      if (acc_wr) begin
        unique case (rs)
          RS_CMD: begin
            if (bus_wdata_i[7]) begin
              sel_q <= TGT_DISP;
              adc_q <= wrap_set(int'(bus_wdata_i[6:0]), DISP_DEPTH);
              st_q  <= ST_PF_REQ;
            end else if (bus_wdata_i[6]) begin
              sel_q <= TGT_PAT;
              adc_q <= wrap_set(int'(bus_wdata_i[5:0]), PAT_DEPTH);
              st_q  <= ST_PF_REQ;
            end
          end
          RS_EXT: begin
            if (bus_wdata_i[7]) begin
              sel_q <= TGT_ARB;
              adc_q <= wrap_set(int'(bus_wdata_i[6:0]), ARB_DEPTH);
              st_q  <= ST_PF_REQ;
            end else begin
              con_q <= bus_wdata_i[CON_W-1:0];
            end
          end
          RS_DATA: begin
            dr_q      <= bus_wdata_i;
            wr_q      <= 1'b1;
            wr_addr_q <= adc_q;
            adc_q     <= adc_step;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rs)
      RS_CMD:  bus_rdata_o = {busy_o, adc_q};
      RS_DATA: bus_rdata_o = dr_q;
      RS_EXT:  bus_rdata_o = DATA_W'(con_q);
      default: bus_rdata_o = '0;
    endcase
  end

  assign mem_req_o   = wr_q | (st_q == ST_PF_REQ);
  assign mem_we_o    = wr_q;
  assign mem_sel_o   = sel_q;
  assign mem_addr_o  = wr_q ? wr_addr_q : adc_q;
  assign mem_wdata_o = dr_q;

  a_r9_adc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, adc_q} < depth);

  a_r3_unsel_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && rs == RS_NONE && !busy_o) |=> !mem_req_o);

  a_r10_busy_drops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !bus_rw_i && busy_o) |=> ($stable(adc_q) && $stable(con_q) && $stable(sel_q)));

  a_r7_mem_under_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

// File: tb/host_reg_if_tb_top.sv
module host_reg_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DD = 80, PD = 64, AD = 24;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_rw = 1'b0, cfg_inc = 1'b1;
  logic [1:0] bus_rs = 2'b10;
  logic [7:0] bus_wd = '0;
  logic [7:0] bus_rdata, mem_wdata, mem_rdata;
  logic       busy, mem_req, mem_we;
  logic [1:0] mem_sel;
  logic [6:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mem_a [0:2][0:127];
  logic [7:0] sh    [0:2][0:127];
  logic [16:0] exp_q [$];

  int m_adc = 0, m_sel = 0, m_con = 0;
  logic [7:0] m_dr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reg_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_rw_i(bus_rw),
    .bus_rs_i(bus_rs), .bus_wdata_i(bus_wd), .bus_rdata_o(bus_rdata),
    .busy_o(busy), .cfg_inc_i(cfg_inc), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_sel_o(mem_sel), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int depth_of(input int s);
    return (s == 1) ? PD : (s == 2) ? AD : DD;
  endfunction

  // memory model and per-cycle port monitor
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem_a[mem_sel][mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_a[mem_sel][mem_addr];
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      chk(int'(mem_addr) < depth_of(int'(mem_sel)), "R9 mem addr range", mem_addr, depth_of(int'(mem_sel)));
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected mem write", {mem_sel, mem_addr, mem_wdata}, 0);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({mem_sel, mem_addr, mem_wdata} == e, "R7 mem write", {mem_sel, mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  function automatic int step(input int a);
    int d;
    d = depth_of(m_sel);
    if (cfg_inc) return (a >= d - 1) ? 0 : a + 1;
    return (a == 0) ? d - 1 : a - 1;
  endfunction

  function automatic logic [7:0] model(input logic [1:0] rs, input logic rw, input logic [7:0] wd);
    logic [7:0] r;
    bit pf;
    r = 8'h00;
    pf = 0;
    case (rs)
      2'b10: begin
        r = {1'b0, 7'(m_adc)};
        if (!rw && wd[7])      begin m_sel = 0; m_adc = int'(wd[6:0]) % DD; pf = 1; end
        else if (!rw && wd[6]) begin m_sel = 1; m_adc = int'(wd[5:0]) % PD; pf = 1; end
      end
      2'b00: begin
        r = 8'(m_con);
        if (!rw && wd[7])  begin m_sel = 2; m_adc = int'(wd[6:0]) % AD; pf = 1; end
        else if (!rw)      m_con = int'(wd[4:0]);
      end
      2'b11: begin
        r = m_dr;
        if (rw) begin m_adc = step(m_adc); pf = 1; end
        else begin
          m_dr = wd;
          sh[m_sel][m_adc] = wd;
          exp_q.push_back({2'(m_sel), 7'(m_adc), wd});
          m_adc = step(m_adc);
        end
      end
      default: ;
    endcase
    if (pf) m_dr = sh[m_sel][m_adc];
    return r;
  endfunction

  task automatic bus(input logic [1:0] rs, input logic rw, input logic [7:0] wd,
                     output logic [7:0] rd, input bit wait_idle);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_wd = wd; bus_en = 1'b1;
    repeat (3) @(negedge clk);
    rd = bus_rdata;
    bus_en = 1'b0;
    if (wait_idle) begin
      repeat (4) @(negedge clk);
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic acc(input logic [1:0] rs, input logic rw, input logic [7:0] wd, input string tag);
    logic [7:0] e, rd;
    e = model(rs, rw, wd);
    bus(rs, rw, wd, rd, 1);
    if (rw) chk(rd == e, tag, rd, e);
  endtask

  initial begin
    logic [7:0] rd;
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 128; i++) begin
        mem_a[t][i] = 8'(t * 64 + i * 5 + 3);
        sh[t][i]    = 8'(t * 64 + i * 5 + 3);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(mem_req == 1'b0, "R1 no mem req after reset", mem_req, 0);
    acc(2'b10, 1, 8'h00, "R1 R4 status after reset");
    acc(2'b00, 1, 8'h00, "R1 R2 extension after reset");
    acc(2'b11, 1, 8'h00, "R1 R2 data port after reset");
    acc(2'b10, 1, 8'h00, "R8 counter stepped by read");
    // unselected code
    acc(2'b01, 1, 8'h00, "R3 unselected read");
    bus(2'b01, 0, 8'hFF, rd, 0);
    chk(busy == 1'b0, "R3 unselected write no busy", busy, 0);
    acc(2'b10, 1, 8'h00, "R3 state kept after unselected write");
    acc(2'b00, 1, 8'h00, "R3 contrast kept after unselected write");
    // display address set, prefetch, read stream
    acc(2'b10, 0, 8'h85, "R5");
    acc(2'b10, 1, 8'h00, "R4 R5 status after display set");
    acc(2'b11, 1, 8'h00, "R6 prefetch after set");
    acc(2'b10, 1, 8'h00, "R8 step after read");
    acc(2'b11, 1, 8'h00, "R8 next word prefetched");
    // write stream
    acc(2'b11, 0, 8'hA5, "R7");
    acc(2'b11, 0, 8'h5A, "R7");
    acc(2'b11, 0, 8'h3C, "R7");
    acc(2'b10, 1, 8'h00, "R7 counter after writes");
    acc(2'b11, 1, 8'h00, "R7 data port holds last write");
    // wrap up and down
    acc(2'b10, 0, 8'hCF, "R5");
    acc(2'b11, 0, 8'h11, "R9");
    acc(2'b10, 1, 8'h00, "R9 wrap up display");
    cfg_inc = 1'b0;
    acc(2'b11, 1, 8'h00, "R9 read at 0");
    acc(2'b10, 1, 8'h00, "R9 wrap down display");
    acc(2'b11, 1, 8'h00, "R9 prefetch at top address");
    // pattern memory
    cfg_inc = 1'b1;
    acc(2'b10, 0, 8'h7F, "R5");
    acc(2'b10, 1, 8'h00, "R5 pattern address");
    acc(2'b11, 1, 8'h00, "R6 pattern prefetch");
    acc(2'b10, 1, 8'h00, "R9 wrap pattern");
    acc(2'b11, 0, 8'hE7, "R7");
    // arbitrator memory
    acc(2'b00, 0, 8'h97, "R5");
    acc(2'b11, 1, 8'h00, "R6 arbitrator prefetch");
    acc(2'b10, 1, 8'h00, "R9 wrap arbitrator");
    acc(2'b00, 0, 8'h9E, "R5");
    acc(2'b10, 1, 8'h00, "R5 arbitrator modulo set");
    acc(2'b11, 0, 8'h42, "R7");
    acc(2'b00, 0, 8'h9E, "R5");
    acc(2'b11, 1, 8'h00, "R7 arbitrator readback");
    // contrast
    acc(2'b00, 0, 8'h1B, "R5");
    acc(2'b00, 1, 8'h00, "R5 contrast readback");
    acc(2'b10, 1, 8'h00, "R5 contrast write keeps counter");
    // busy window
    void'(model(2'b10, 0, 8'h8A));
    bus(2'b10, 0, 8'h8A, rd, 0);
    chk(busy == 1'b1, "R10 busy after write", busy, 1);
    bus(2'b10, 0, 8'h94, rd, 1);
    acc(2'b10, 1, 8'h00, "R10 write during busy ignored");
    void'(model(2'b10, 0, 8'h82));
    bus(2'b10, 0, 8'h82, rd, 0);
    bus(2'b11, 0, 8'h77, rd, 1);
    acc(2'b10, 1, 8'h00, "R10 data write during busy ignored");
    acc(2'b11, 1, 8'h00, "R10 data port unchanged");
    void'(model(2'b10, 0, 8'h83));
    bus(2'b10, 0, 8'h83, rd, 0);
    bus(2'b10, 1, 8'h00, rd, 1);
    chk(rd[7] == 1'b1, "R4 busy bit in status", rd[7], 1);
    acc(2'b10, 1, 8'h00, "R4 status after busy clears");
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all writes committed", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule